// File: doc/BRIEF.md
# Fast-Page DRAM Line Burst Sequencer

This block runs single accesses and short bursts against an asynchronous DRAM whose row and column addresses share one set of address pins. A requester hands over a bus-word address, a transfer size and a direction through a ready/valid handshake. The block then produces the chip-select, row strobe, column strobe, bus-start and read/write pins. It also puts the row and then the column on the shared address pins, and it moves data over a DATA_W-bit bus with separate input, output and output-enable signals.

Transfers larger than one bus word become bursts inside an aligned block of the transfer size, at most one line. A read of a full line serves a cache fill and a write of a full line serves a cache write-back. The first beat is the word named by the address. The following beats step upward and wrap back to the start of the aligned block. A configuration input, sampled when the request is accepted, selects between fast-page operation and plain operation. Fast-page operation opens the row once and steps only the column. Plain operation runs a full row-open, column and precharge sequence for every beat. Read words come back with a one-cycle valid pulse and their beat index. Write words are pulled from the requester one cycle before they are needed.

Top module: `fpm_burst_ctrl`

## Requirements
- R1: `req_ready` is high only while no access is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` returns high only in the cycle after the final precharge cycle, and it stays low for the whole of any access.
- R2: `req_size` gives log2 of the transfer size in bytes. A size that fits one bus word (up to log2(DATA_W/8)) makes one beat. Each step above that doubles the beat count, up to LINE_BYTES/(DATA_W/8) beats (4 with defaults: size 3 gives 1 beat, size 4 gives 2 beats, size 5 and above give 4 beats).
- R3: The address is a bus-word address. The column is `req_addr[COL_W-1:0]` and the row is `req_addr[COL_W+ROW_W-1:COL_W]`. With c the start column and m the beat count minus one, beat k uses column (c & ~m) | ((c + k) & m), and the same row for every beat.
- R4: With `cfg_burst_en` high when the request is accepted, the access is two row cycles, then two column cycles per beat, then one precharge cycle (3 + 2·beats cycles with chip select low), and the row strobe falls exactly once.
- R5: With `cfg_burst_en` low when the request is accepted, every beat runs its own two row cycles, two column cycles and one precharge cycle (5·beats cycles with chip select low), and the row strobe falls once per beat.
- R6: All DRAM strobes are active low. Chip select is low from the first row cycle through the last precharge cycle. The row strobe is low from the second row cycle through the second column cycle of the same row. The column strobe is low in each beat's second column cycle. Bus-start is low in each beat's first column cycle. The address pins hold the row in both row cycles and the beat's column in both column cycles.
- R7: On reads, `dram_dq_in` is sampled at the clock edge that ends each second column cycle. `rd_valid` is then high for exactly the next cycle, with that word on `rd_data` and its beat index (column bits [log2(beats per line)-1:0]) on `rd_idx`.
- R8: On writes, `dram_rd_wr` is low for the whole access. `wr_req` is high for one cycle just before each beat's first column cycle, with that beat's index on `wr_idx`. The `wr_data` present in that cycle is driven on `dram_dq_out`, with `dram_dq_oe` high, during both column cycles of the beat.
- R9: While `rst_n` is low, chip select, row strobe, column strobe and bus-start are high, `dram_rd_wr` is high, `req_ready` is high, and `rd_valid`, `wr_req` and `dram_dq_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_burst_en | input | 1 | 1: fast-page bursts, 0: full row cycle per beat; sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1: write (write-back), 0: read (fill) |
| req_size | input | SIZE_W | log2 of transfer size in bytes |
| req_addr | input | COL_W+ROW_W | Bus-word address: row above column |
| wr_req | output | 1 | Write word wanted in this cycle |
| wr_idx | output | log2(beats per line) | Beat index of the wanted write word |
| wr_data | input | DATA_W | Write word, valid while wr_req is high |
| rd_valid | output | 1 | Read word valid pulse |
| rd_idx | output | log2(beats per line) | Beat index of the read word |
| rd_data | output | DATA_W | Read word |
| dram_cs_n | output | 1 | Chip select |
| dram_ras_n | output | 1 | Row strobe |
| dram_cas_n | output | 1 | Column strobe |
| dram_bs_n | output | 1 | Bus-start strobe, one cycle per beat |
| dram_rd_wr | output | 1 | 1: read, 0: write |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Data to DRAM |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | DATA_W | Data from DRAM |

## Verification
The embedded properties watch the handshake and strobe relations on every cycle. A taken request must open with chip select low and the row strobe still high. The precharge cycle must come before ready returns. Bus-start must be followed by the column strobe, and the row address must be held steady across the row-strobe fall. A write-word request must be followed by that word on the data pins. A read valid must follow a column strobe on a read, and the beat counter must stay inside its block. Whether the wrap order hits the right columns, whether the right row is opened, and whether the cycle and strobe counts match the two modes for each size can only be shown by the bench's scenarios. There, a DRAM model returns address-derived data and a scoreboard compares every beat.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ROW1 = 3'd1,
      ST_ROW2 = 3'd2,
      ST_COL1 = 3'd3,
      ST_COL2 = 3'd4,
      ST_PRE  = 3'd5
   } dpb_state_e;

   // Beat index inside an aligned block: bits outside the mask come from the
   // start index, bits inside the mask count up from it and wrap.
   function automatic logic [7:0] dpb_wrap(input logic [7:0] start,
                                           input logic [7:0] step,
                                           input logic [7:0] mask);
      return (start & ~mask) | ((start + step) & mask);
   endfunction

endpackage

// File: rtl/dpb_addr_map.sv
module dpb_addr_map
   import dpb_pkg::*;
#(
   parameter int COL_W   = 10,
   parameter int ROW_W   = 12,
   parameter int BEAT_LG = 2,
   localparam int AW     = COL_W + ROW_W,
   localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
)(
   input  logic [AW-1:0]      addr,
   input  logic [BEAT_LG-1:0] mask,
   input  logic [BEAT_LG-1:0] k_cur,
   input  logic [BEAT_LG-1:0] k_wr,
   output logic [MA_W-1:0]    row_ma,
   output logic [MA_W-1:0]    col_ma,
   output logic [BEAT_LG-1:0] idx_cur,
   output logic [BEAT_LG-1:0] idx_wr
);

   logic [COL_W-1:0]   col_base;
   logic [ROW_W-1:0]   row_base;
   logic [BEAT_LG-1:0] start_idx;
   logic [COL_W-1:0]   col_beat;

   assign col_base  = addr[COL_W-1:0];
   assign row_base  = addr[AW-1:COL_W];
   assign start_idx = col_base[BEAT_LG-1:0];

   assign idx_cur = BEAT_LG'(dpb_wrap(8'(start_idx), 8'(k_cur), 8'(mask)));
   assign idx_wr  = BEAT_LG'(dpb_wrap(8'(start_idx), 8'(k_wr), 8'(mask)));

   generate
      if (COL_W > BEAT_LG) begin : g_col_hi
         assign col_beat = {col_base[COL_W-1:BEAT_LG], idx_cur};
      end else begin : g_col_only
         assign col_beat = idx_cur;
      end

      if (MA_W > ROW_W) begin : g_row_pad
         assign row_ma = {{(MA_W-ROW_W){1'b0}}, row_base};
      end else begin : g_row_full
         assign row_ma = row_base;
      end

      if (MA_W > COL_W) begin : g_col_pad
         assign col_ma = {{(MA_W-COL_W){1'b0}}, col_beat};
      end else begin : g_col_full
         assign col_ma = col_beat;
      end
   endgenerate

endmodule

// File: rtl/dpb_seq.sv
module dpb_seq
   import dpb_pkg::*;
#(
   parameter int AW      = 22,
   parameter int SIZE_W  = 3,
   parameter int BUS_LG  = 3,
   parameter int BEAT_LG = 2
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_burst_en,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [SIZE_W-1:0]  req_size,
   input  logic [AW-1:0]      req_addr,
   output logic               req_ready,
   output logic [AW-1:0]      addr_q,
   output logic [BEAT_LG-1:0] mask_q,
   output logic [BEAT_LG-1:0] k_cur,
   output logic [BEAT_LG-1:0] k_wr,
   output logic               cs_n,
   output logic               ras_n,
   output logic               cas_n,
   output logic               bs_n,
   output logic               rd_wr,
   output logic               row_phase,
   output logic               col_phase,
   output logic               cap_en,
   output logic               wr_req,
   output logic               dq_oe
);

   dpb_state_e         state, state_d;
   logic [BEAT_LG-1:0] k_q, k_d, mask_d;
   logic               wr_q, burst_q, done_q, done_d;
   logic               accept, last_beat;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_ready && req_valid;
   assign last_beat = (k_q == mask_q);

   // Beat count doubles for every size step above one bus word, capped at a line.
   always_comb begin
      for (int i = 0; i < BEAT_LG; i++) begin
         mask_d[i] = (int'(req_size) > (BUS_LG + i));
      end
   end

   always_comb begin
      state_d = state;
      k_d     = k_q;
      done_d  = done_q;
      case (state)
         ST_IDLE: begin
            if (req_valid) begin
               state_d = ST_ROW1;
               k_d     = '0;
               done_d  = 1'b0;
            end
         end
         ST_ROW1: state_d = ST_ROW2;
         ST_ROW2: state_d = ST_COL1;
         ST_COL1: state_d = ST_COL2;
         ST_COL2: begin
            if (last_beat) begin
               state_d = ST_PRE;
               done_d  = 1'b1;
            end else begin
               k_d     = BEAT_LG'(k_q + 1'b1);
               state_d = burst_q ? ST_COL1 : ST_PRE;
            end
         end
         ST_PRE:  state_d = done_q ? ST_IDLE : ST_ROW1;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         k_q     <= '0;
         done_q  <= 1'b0;
         addr_q  <= '0;
         mask_q  <= '0;
         wr_q    <= 1'b0;
         burst_q <= 1'b0;
      end else begin
         state  <= state_d;
         k_q    <= k_d;
         done_q <= done_d;
         if (accept) begin
            addr_q  <= req_addr;
            mask_q  <= mask_d;
            wr_q    <= req_write;
            burst_q <= cfg_burst_en;
         end
      end
   end

   assign k_cur     = k_q;
   assign k_wr      = (state == ST_ROW2) ? k_q : BEAT_LG'(k_q + 1'b1);

   assign cs_n      = (state == ST_IDLE);
   assign ras_n     = !((state == ST_ROW2) || (state == ST_COL1) || (state == ST_COL2));
   assign cas_n     = (state != ST_COL2);
   assign bs_n      = (state != ST_COL1);
   assign rd_wr     = !(wr_q && (state != ST_IDLE));
   assign row_phase = (state == ST_ROW1) || (state == ST_ROW2);
   assign col_phase = (state == ST_COL1) || (state == ST_COL2);
   assign cap_en    = (state == ST_COL2) && !wr_q;
   assign wr_req    = wr_q && ((state == ST_ROW2) ||
                               ((state == ST_COL2) && burst_q && !last_beat));
   assign dq_oe     = wr_q && col_phase;

   AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ((k_q & ~mask_q) == '0)); // R2

endmodule

// File: rtl/dpb_data.sv
module dpb_data #(
   parameter int DATA_W  = 64,
   parameter int BEAT_LG = 2
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap_en,
   input  logic [BEAT_LG-1:0] cap_idx,
   input  logic [DATA_W-1:0]  dq_in,
   input  logic               wr_take,
   input  logic [DATA_W-1:0]  wr_data,
   output logic               rd_valid,
   output logic [BEAT_LG-1:0] rd_idx,
   output logic [DATA_W-1:0]  rd_data,
   output logic [DATA_W-1:0]  dq_out
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_idx   <= '0;
         rd_data  <= '0;
         dq_out   <= '0;
      end else begin
         rd_valid <= cap_en;
         if (cap_en) begin
            rd_data <= dq_in;
            rd_idx  <= cap_idx;
         end
         if (wr_take) begin
            dq_out <= wr_data;
         end
      end
   end

endmodule

// File: rtl/fpm_burst_ctrl.sv
module fpm_burst_ctrl #(
   parameter int DATA_W     = 64,
   parameter int LINE_BYTES = 32,
   parameter int COL_W      = 10,
   parameter int ROW_W      = 12,
   parameter int SIZE_W     = 3,
   localparam int BUS_LG    = $clog2(DATA_W / 8),
   localparam int BEAT_LG   = $clog2(LINE_BYTES) - BUS_LG,
   localparam int AW        = COL_W + ROW_W,
   localparam int MA_W      = (ROW_W > COL_W) ? ROW_W : COL_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_burst_en,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_write,
   input  logic [SIZE_W-1:0]  req_size,
   input  logic [AW-1:0]      req_addr,
   output logic               wr_req,
   output logic [BEAT_LG-1:0] wr_idx,
   input  logic [DATA_W-1:0]  wr_data,
   output logic               rd_valid,
   output logic [BEAT_LG-1:0] rd_idx,
   output logic [DATA_W-1:0]  rd_data,
   output logic               dram_cs_n,
   output logic               dram_ras_n,
   output logic               dram_cas_n,
   output logic               dram_bs_n,
   output logic               dram_rd_wr,
   output logic [MA_W-1:0]    dram_addr,
   output logic [DATA_W-1:0]  dram_dq_out,
   output logic               dram_dq_oe,
   input  logic [DATA_W-1:0]  dram_dq_in
);

   generate
      if ((8 << BUS_LG) != DATA_W) begin : g_bad_bus
         $error("DATA_W must be a power-of-two number of bytes");
      end
      if (LINE_BYTES != (1 << $clog2(LINE_BYTES)) || BEAT_LG < 1 || BEAT_LG > 8) begin : g_bad_line
         $error("LINE_BYTES must be a power of two, 2 to 256 bus words");
      end
      if (COL_W < BEAT_LG) begin : g_bad_col
         $error("COL_W must cover the beat index");
      end
      if ((1 << SIZE_W) <= (BUS_LG + BEAT_LG)) begin : g_bad_size
         $error("SIZE_W too narrow to name a full line");
      end
   endgenerate

   logic [AW-1:0]      addr_q;
   logic [BEAT_LG-1:0] mask_q, k_cur, k_wr, idx_cur;
   logic [MA_W-1:0]    row_ma, col_ma;
   logic               row_phase, col_phase, cap_en;

   dpb_seq #(
      .AW      (AW),
      .SIZE_W  (SIZE_W),
      .BUS_LG  (BUS_LG),
      .BEAT_LG (BEAT_LG)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_burst_en (cfg_burst_en),
      .req_valid    (req_valid),
      .req_write    (req_write),
      .req_size     (req_size),
      .req_addr     (req_addr),
      .req_ready    (req_ready),
      .addr_q       (addr_q),
      .mask_q       (mask_q),
      .k_cur        (k_cur),
      .k_wr         (k_wr),
      .cs_n         (dram_cs_n),
      .ras_n        (dram_ras_n),
      .cas_n        (dram_cas_n),
      .bs_n         (dram_bs_n),
      .rd_wr        (dram_rd_wr),
      .row_phase    (row_phase),
      .col_phase    (col_phase),
      .cap_en       (cap_en),
      .wr_req       (wr_req),
      .dq_oe        (dram_dq_oe)
   );

   dpb_addr_map #(
      .COL_W   (COL_W),
      .ROW_W   (ROW_W),
      .BEAT_LG (BEAT_LG)
   ) u_map (
      .addr    (addr_q),
      .mask    (mask_q),
      .k_cur   (k_cur),
      .k_wr    (k_wr),
      .row_ma  (row_ma),
      .col_ma  (col_ma),
      .idx_cur (idx_cur),
      .idx_wr  (wr_idx)
   );

   dpb_data #(
      .DATA_W  (DATA_W),
      .BEAT_LG (BEAT_LG)
   ) u_data (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .cap_idx  (idx_cur),
      .dq_in    (dram_dq_in),
      .wr_take  (wr_req),
      .wr_data  (wr_data),
      .rd_valid (rd_valid),
      .rd_idx   (rd_idx),
      .rd_data  (rd_data),
      .dq_out   (dram_dq_out)
   );

   assign dram_addr = row_phase ? row_ma : (col_phase ? col_ma : '0);

   AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!dram_cs_n && dram_ras_n && !req_ready)); // R1
   AST_PRE_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_ready) |-> $past(!dram_cs_n && dram_ras_n && dram_cas_n)); // R1
   AST_BS_THEN_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_bs_n |=> (!dram_cas_n && dram_bs_n)); // R6
   AST_ROW_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> ($stable(dram_addr) && !dram_cs_n)); // R6
   AST_WREQ_THEN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |=> (!dram_bs_n && dram_dq_oe && (dram_dq_out == $past(wr_data)))); // R8
   AST_RD_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(!dram_cas_n && dram_rd_wr)); // R7

endmodule

// File: tb/test_fpm_burst_ctrl.sv
module test_fpm_burst_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 64;
   localparam int COL_W      = 10;
   localparam int ROW_W      = 12;
   localparam int AW         = COL_W + ROW_W;
   localparam int MA_W       = 12;
   localparam int WDOG       = 20000;

   typedef struct {
      logic [63:0] data;
      int          idx;
      int          col;
      int          row;
   } item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_burst_en = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_write = 1'b0;
   logic [2:0]        req_size = '0;
   logic [AW-1:0]     req_addr = '0;
   logic              wr_req;
   logic [1:0]        wr_idx;
   logic [DATA_W-1:0] wr_data;
   logic              rd_valid;
   logic [1:0]        rd_idx;
   logic [DATA_W-1:0] rd_data;
   logic              dram_cs_n, dram_ras_n, dram_cas_n, dram_bs_n, dram_rd_wr, dram_dq_oe;
   logic [MA_W-1:0]   dram_addr;
   logic [DATA_W-1:0] dram_dq_out;
   logic [DATA_W-1:0] dram_dq_in = '0;

   logic [31:0] wseed = '0;
   int total = 0;
   int bad = 0;
   int cs_cnt, ras_cnt, cas_cnt, rd_cnt, ready_bad;
   int row_l = 0;
   logic prev_ras = 1'b1;
   bit finished = 1'b0;
   item_t rq[$];
   item_t wq[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   assign wr_data = {wseed, 30'd0, wr_idx};

   fpm_burst_ctrl i_fpm_burst_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_burst_en (cfg_burst_en),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_write    (req_write),
      .req_size     (req_size),
      .req_addr     (req_addr),
      .wr_req       (wr_req),
      .wr_idx       (wr_idx),
      .wr_data      (wr_data),
      .rd_valid     (rd_valid),
      .rd_idx       (rd_idx),
      .rd_data      (rd_data),
      .dram_cs_n    (dram_cs_n),
      .dram_ras_n   (dram_ras_n),
      .dram_cas_n   (dram_cas_n),
      .dram_bs_n    (dram_bs_n),
      .dram_rd_wr   (dram_rd_wr),
      .dram_addr    (dram_addr),
      .dram_dq_out  (dram_dq_out),
      .dram_dq_oe   (dram_dq_oe),
      .dram_dq_in   (dram_dq_in)
   );

   function automatic logic [63:0] rpat(input int row, input int col);
      return {16'hC0DE, 16'(row), 32'(col) ^ 32'h5A00_0000};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // DRAM model and monitor: everything sampled mid-cycle.
   always @(negedge clk) begin
      if (rst_n) begin
         if (!dram_cs_n) cs_cnt++;
         if (!dram_cs_n && req_ready) ready_bad++;
         if (!dram_ras_n && prev_ras) begin
            ras_cnt++;
            row_l = int'(dram_addr);
         end
         if (!dram_cas_n) begin
            cas_cnt++;
            if (dram_rd_wr) begin
               dram_dq_in = rpat(row_l, int'(dram_addr));
            end else if (wq.size() == 0) begin
               chk(1'b0, "R8 unexpected write beat", 64'(dram_addr), 64'd0);
            end else begin
               item_t it;
               it = wq.pop_front();
               chk(int'(dram_addr) == it.col, "R3 write column", 64'(dram_addr), 64'(it.col));
               chk(row_l == it.row, "R3 write row", 64'(row_l), 64'(it.row));
               chk(dram_dq_oe && dram_dq_out == it.data, "R8 write data", dram_dq_out, it.data);
            end
         end
         if (rd_valid) begin
            rd_cnt++;
            if (rq.size() == 0) begin
               chk(1'b0, "R7 unexpected read valid", rd_data, 64'd0);
            end else begin
               item_t it;
               it = rq.pop_front();
               chk(rd_data == it.data, "R3 R7 read data order", rd_data, it.data);
               chk(int'(rd_idx) == it.idx, "R7 read index", 64'(rd_idx), 64'(it.idx));
            end
         end
         prev_ras = dram_ras_n;
      end
   end

   task automatic run(input int addr, input int size, input bit wr, input bit burst);
      int n, m, c, row, exp_cs;
      n   = (size <= 3) ? 1 : ((size == 4) ? 2 : 4);
      m   = n - 1;
      c   = addr & ((1 << COL_W) - 1);
      row = addr >> COL_W;
      wseed = 32'(addr) ^ 32'hBEEF_0000;
      for (int k = 0; k < n; k++) begin
         item_t it;
         int ck;
         ck = (c & ~m) | ((c + k) & m);
         it.col  = ck;
         it.row  = row;
         it.idx  = ck & 3;
         it.data = wr ? {wseed, 32'(ck & 3)} : rpat(row, ck);
         if (wr) wq.push_back(it);
         else    rq.push_back(it);
      end
      cs_cnt = 0; ras_cnt = 0; cas_cnt = 0; rd_cnt = 0; ready_bad = 0;
      @(negedge clk);
      cfg_burst_en = burst;
      req_addr     = AW'(addr);
      req_size     = 3'(size);
      req_write    = wr;
      req_valid    = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready && !dram_cs_n && dram_ras_n, "R1 accept starts row cycle",
          {62'd0, req_ready, dram_cs_n}, 64'd0);
      chk(dram_addr == MA_W'(row), "R6 row on address pins", 64'(dram_addr), 64'(row));
      chk(dram_rd_wr == !wr, "R8 direction pin", 64'(dram_rd_wr), 64'(!wr));
      while (!req_ready) @(negedge clk);
      exp_cs = burst ? (3 + 2 * n) : (5 * n);
      chk(cs_cnt == exp_cs, burst ? "R4 burst cycle count" : "R5 plain cycle count",
          64'(cs_cnt), 64'(exp_cs));
      chk(ras_cnt == (burst ? 1 : n), burst ? "R4 single row open" : "R5 row open per beat",
          64'(ras_cnt), 64'(burst ? 1 : n));
      chk(cas_cnt == n, "R2 beat count", 64'(cas_cnt), 64'(n));
      chk(rd_cnt == (wr ? 0 : n), "R7 read pulse count", 64'(rd_cnt), 64'(wr ? 0 : n));
      chk(rq.size() == 0 && wq.size() == 0, "R3 all beats seen",
          64'(rq.size() + wq.size()), 64'd0);
      chk(ready_bad == 0, "R1 ready low while busy", 64'(ready_bad), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(dram_cs_n && dram_ras_n && dram_cas_n && dram_bs_n, "R9 strobes idle in reset",
          {60'd0, dram_cs_n, dram_ras_n, dram_cas_n, dram_bs_n}, 64'hF);
      chk(req_ready && dram_rd_wr, "R9 ready and read level in reset",
          {62'd0, req_ready, dram_rd_wr}, 64'h3);
      chk(!rd_valid && !wr_req && !dram_dq_oe, "R9 pulses low in reset",
          {61'd0, rd_valid, wr_req, dram_dq_oe}, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(req_ready && dram_cs_n, "R1 idle without request", {62'd0, req_ready, dram_cs_n}, 64'h3);

      run((22'h155 << COL_W) | 22'h0A6, 5, 1'b0, 1'b1); // fill, start beat 2: R3 R4 R7
      run((22'h0F3 << COL_W) | 22'h3F1, 5, 1'b1, 1'b1); // write-back, start beat 1: R3 R4 R8
      run((22'h801 << COL_W) | 22'h013, 5, 1'b0, 1'b0); // plain fill, start 3: R5
      run((22'h7FF << COL_W) | 22'h3FC, 5, 1'b1, 1'b0); // plain write-back, start 0: R5 R8
      run((22'h012 << COL_W) | 22'h20B, 3, 1'b0, 1'b1); // one word: R2
      run((22'h345 << COL_W) | 22'h1F7, 4, 1'b0, 1'b1); // half line, start 3: R2 R3
      run((22'h0AA << COL_W) | 22'h102, 4, 1'b1, 1'b0); // half line write, plain: R2 R5
      run((22'h3C3 << COL_W) | 22'h0E5, 0, 1'b1, 1'b1); // byte write: R2 R8
      run((22'hABC << COL_W) | 22'h3FF, 7, 1'b0, 1'b1); // oversize capped at line: R2

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog R1 act=%0d exp=%0d", WDOG, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule